// File: doc/BRIEF.md
# Gated-Write Board Control Register Bank

A byte-wide register bank that sits on a simple synchronous host bus (chip select, read strobe, write strobe, byte address). It exposes three registers on 32-bit boundaries: a read-only design revision, a read-only snapshot of board status lines, and a control register. The control register drives two active-low board outputs: a power-on-self-test indicator and a reset line to a carrier.

Every control flag has a companion gate bit in the same byte. A write changes a flag only when that write also carries a 1 in the flag's gate bit. Software can therefore change one flag with a single write and needs no read-modify-write, because flags whose gate is 0 keep their value. Gate bits are not stored.

Status lines enter through a two-flop synchronizer. Read data is registered and appears in the cycle after the read strobe.

Top module: `gcr_top`

## Requirements
- R1: While rst_ni is low and after its release with no write, post_led_no = 0 (LED on), reset_out_no = 0 (carrier reset asserted) and rdata_o = 0x00.
- R2: A read at offset 0 returns the REVISION parameter in bits 3:0 and 0 in bits 7:4.
- R3: A write at offset 8 loads bit 0 of the data into the POST flag (post_led_no) only when bit 1 of the same data is 1. Otherwise the flag holds.
- R4: A write at offset 8 loads bit 6 of the data into the reset flag (reset_out_no) only when bit 7 of the same data is 1. Writing 0x80 drives reset_out_no low, 0xC0 drives it high, and 0x03 drives post_led_no high.
- R5: A read at offset 8 returns the reset flag in bit 6 (1 = inactive) and the POST flag in bit 0. All other bits, gate bits included, read 0.
- R6: A read at offset 4 returns status_i once status_i has been stable for at least two clock edges before the read edge.
- R7: Writes to offsets other than 8 leave both flags unchanged.
- R8: Reads at any offset other than 0, 4 or 8 return 0x00.
- R9: rdata_o takes the addressed value at the clock edge where cs_i and rd_i are both high, and returns to 0x00 after any edge without a read.
- R10: With cs_i low, wr_i and rd_i have no effect: the flags hold and rdata_o stays 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| status_i | input | 8 | Asynchronous board status lines |
| post_led_no | output | 1 | POST indicator, active low |
| reset_out_no | output | 1 | Carrier reset, active low |

## Verification
On every cycle the assertions check the gating rule of each flag, that flags hold without chip select, that revision and reserved reads return the right data, that control readback matches the output pins, and that read data is cleared after idle cycles. Only the bench scenarios can show the full write-value sweep against an arithmetic model, the synchronizer latency on status lines across all byte values, and the reset values. They also show that the named write codes give the intended pin levels.

// File: rtl/gcr_pkg.sv
package gcr_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned N_FLAGS = 2;

  typedef enum logic [1:0] {SEL_VER, SEL_STAT, SEL_CTL, SEL_NONE} sel_e;

  // flag 0: POST indicator, flag 1: carrier reset
  function automatic int unsigned flag_pos(int unsigned idx);
    return (idx == 0) ? 0 : 6;
  endfunction

  function automatic int unsigned gate_pos(int unsigned idx);
    return flag_pos(idx) + 1;
  endfunction
endpackage

// File: rtl/gcr_sync.sv
module gcr_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gcr_gated_bit.sv
module gcr_gated_bit #(
  parameter int unsigned DW       = 8,
  parameter int unsigned FLAG_POS = 0,
  parameter int unsigned GATE_POS = 1,
  parameter logic        RST_VAL  = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic          flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        flag_q <= RST_VAL;
    else if (we_i && wdata_i[GATE_POS]) flag_q <= wdata_i[FLAG_POS];
  end

  assign flag_o = flag_q;

  // R3 for the POST flag, R4 for the reset flag (same instance type)
  p_gate_closed_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wdata_i[GATE_POS]) |=> $stable(flag_o));
  p_no_write_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(flag_o));
  p_gate_open_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wdata_i[GATE_POS]) |=> (flag_o == $past(wdata_i[FLAG_POS])));
endmodule

// File: rtl/gcr_top.sv
module gcr_top
  import gcr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned OFF_VER  = 0,
  parameter int unsigned OFF_STAT = 4,
  parameter int unsigned OFF_CTL  = 8,
  parameter logic [3:0]  REVISION = 4'h5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [DATA_W-1:0] status_i,
  output logic              post_led_no,
  output logic              reset_out_no
);
  localparam logic [ADDR_W-1:0] A_VER  = ADDR_W'(OFF_VER);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFF_CTL);

  sel_e              sel;
  logic              ctl_we, rd_en;
  logic [N_FLAGS-1:0] flags;
  logic [DATA_W-1:0] stat_sync, ctl_rd, rd_mux, rdata_q;

  always_comb begin
    if      (addr_i == A_VER)  sel = SEL_VER;
    else if (addr_i == A_STAT) sel = SEL_STAT;
    else if (addr_i == A_CTL)  sel = SEL_CTL;
    else                       sel = SEL_NONE;
  end

  assign ctl_we = cs_i && wr_i && (sel == SEL_CTL);
  assign rd_en  = cs_i && rd_i;

  gcr_sync #(.W(DATA_W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (status_i),
    .q_o   (stat_sync)
  );

  for (genvar g = 0; g < N_FLAGS; g++) begin : g_flag
    gcr_gated_bit #(
      .DW      (DATA_W),
      .FLAG_POS(flag_pos(g)),
      .GATE_POS(gate_pos(g)),
      .RST_VAL (1'b0)
    ) u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (ctl_we),
      .wdata_i(wdata_i),
      .flag_o (flags[g])
    );
  end

  always_comb begin
    ctl_rd = '0;
    for (int i = 0; i < N_FLAGS; i++) ctl_rd[flag_pos(i)] = flags[i];
  end

  always_comb begin
    unique case (sel)
      SEL_VER:  rd_mux = {{(DATA_W-4){1'b0}}, REVISION};
      SEL_STAT: rd_mux = stat_sync;
      SEL_CTL:  rd_mux = ctl_rd;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_en ? rd_mux : '0;
  end

  assign rdata_o      = rdata_q;
  assign post_led_no  = flags[0];
  assign reset_out_no = flags[1];

  p_rdata_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cs_i && rd_i) |=> (rdata_o == '0));
  p_ver_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && addr_i == A_VER) |=> (rdata_o[3:0] == REVISION && rdata_o[7:4] == 4'h0));
  p_rsvd_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && sel == SEL_NONE) |=> (rdata_o == '0));
  p_ctl_readback_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_i && rd_i && addr_i == A_CTL) |=>
      (rdata_o[6] == $past(reset_out_no) && rdata_o[0] == $past(post_led_no)
       && (rdata_o & 8'hBE) == 8'h00));
  p_nocs_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> ($stable(post_led_no) && $stable(reset_out_no)));
endmodule

// File: tb/gcr_top_tb.sv
module gcr_top_tb;
  localparam logic [3:0] REV = 4'h5;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0, rdata, status = '0;
  logic       post_n, rst_n;
  int         n_run = 0, n_fail = 0;
  logic       e_post = 1'b0, e_rst = 1'b0;

  always #5 clk = ~clk;

  gcr_top #(.REVISION(REV)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .status_i(status),
    .post_led_no(post_n), .reset_out_no(rst_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [3:0] a, input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk); cs = sel; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); cs = 1'b0; wr = 1'b0;
  endtask

  task automatic do_rd(input logic [3:0] a, output logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk); cs = sel; rd = 1'b1; addr = a;
    @(negedge clk); cs = 1'b0; rd = 1'b0; d = rdata;
  endtask

  function automatic logic [7:0] ctl_exp();
    return {1'b0, e_rst, 5'b0, e_post};
  endfunction

  task automatic chk_pins(input string req);
    check(req, {6'b0, rst_n, post_n}, {6'b0, e_rst, e_post});
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    check("R1 reset pins", {6'b0, rst_n, post_n}, 8'h00);
    check("R1 reset rdata", rdata, 8'h00);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk_pins("R1 after release");
    do_rd(4'd8, r); check("R1 ctl after reset", r, 8'h00);

    do_rd(4'd0, r); check("R2 revision", r, {4'h0, REV});

    // R3/R4/R5: sweep every written byte against the gating model
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      b = 8'(v);
      do_wr(4'd8, b);
      if (b[1]) e_post = b[0];
      if (b[7]) e_rst  = b[6];
      check("R3 post flag", {7'b0, post_n}, {7'b0, e_post});
      check("R4 reset flag", {7'b0, rst_n}, {7'b0, e_rst});
      do_rd(4'd8, r); check("R5 ctl readback", r, ctl_exp());
    end

    do_wr(4'd8, 8'h80); e_rst = 1'b0;  chk_pins("R4 0x80 asserts");
    do_wr(4'd8, 8'hC0); e_rst = 1'b1;  chk_pins("R4 0xC0 releases");
    do_wr(4'd8, 8'h02); e_post = 1'b0; chk_pins("R3 led on");
    do_wr(4'd8, 8'h03); e_post = 1'b1; chk_pins("R4 0x03 led off");

    // R7: writes elsewhere that would clear both flags if decoded
    for (int a = 0; a < 16; a++) begin
      if (a != 8) begin
        do_wr(4'(a), 8'h82);
        chk_pins("R7 non-ctl write");
        do_rd(4'd8, r); check("R7 ctl readback", r, ctl_exp());
      end
    end

    // R6: status through synchronizer
    for (int s = 0; s < 256; s++) begin
      @(negedge clk); status = 8'(s);
      @(negedge clk);
      do_rd(4'd4, r); check("R6 status", r, 8'(s));
    end

    // R8/R2/R6/R5 across the whole address space
    for (int a = 0; a < 16; a++) begin
      logic [7:0] ex;
      ex = (a == 0) ? {4'h0, REV} : (a == 4) ? status : (a == 8) ? ctl_exp() : 8'h00;
      do_rd(4'(a), r); check("R8 address map read", r, ex);
    end

    // R9: rdata clears after an idle edge
    do_rd(4'd0, r);
    @(negedge clk); check("R9 idle clears", rdata, 8'h00);

    // R10: strobes without chip select
    do_wr(4'd8, 8'h82, 1'b0); chk_pins("R10 write without cs");
    do_rd(4'd0, r, 1'b0); check("R10 read without cs", r, 8'h00);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule